// File: doc/BRIEF.md
# I2C Bit-Level Command Controller

This block is the lowest layer of an I2C master. A higher-level sequencer issues one bus command at a time: start, repeated start, stop, write one bit, or read one bit. The block turns that command into the matching SCL/SDA waveform. Acknowledge phases use the read command from the master's side. A separate sequencer handles byte assembly, addressing and ordering.

A quarter-period timer splits every command into four equal phases, named A, B, C and D. The block returns to idle after phase D and raises a one-cycle completion pulse. The phase length is derived from the system clock frequency and a mode parameter (standard or fast). It is rounded up so that no SCL high or low minimum and no start or stop setup minimum is undershot.

Both lines are open-drain. The block only produces pull-down enables, and a released line is pulled high by an external resistor. In a read, SDA is released and the line value is captured at the end of phase C, while SCL is high.

Top module: `i2c_bit_ctrl`

## Requirements
- R1: When rst_ni is low, both pull-down enables are 0 at once (asynchronously), busy_o is 0, done_o is 0 and rd_bit_o is 0.
- R2: Each phase lasts QUARTER clocks. QUARTER is ceil(CLK_HZ * max(t_low, t_high, 2*t_su_sta, 2*t_su_sto) / 2), which gives 130 at 200 MHz in fast mode. done_o is high for exactly one clock, 4*QUARTER clocks after the accepting edge, and busy_o falls in that same cycle.
- R3: Start (cmd_i = 1) gives the line levels SCL H,H,H,L and SDA H,L,L,L in phases A..D, so SDA falls before SCL.
- R4: Repeated start (cmd_i = 2) gives SCL L,H,H,L and SDA H,H,L,L in phases A..D.
- R5: Stop (cmd_i = 3) gives SCL L,H,H,H and SDA L,L,H,H in phases A..D, so SDA rises while SCL is high.
- R6: Write bit (cmd_i = 4) gives SCL L,H,H,L. SDA equals the wr_bit_i value latched at acceptance and stays unchanged through all four phases.
- R7: Read bit (cmd_i = 5) gives SCL L,H,H,L and keeps SDA released. rd_bit_o takes the sda_i value present at the end of phase C and keeps it until the next read or reset.
- R8: A line is never driven high. The outputs are pull-down enables (1 = pull low, 0 = release), and both are 0 whenever busy_o is 0.
- R9: A command is accepted only when the block is idle and cmd_i is one of 1..5. cmd_valid_i while busy, and codes 0, 6 and 7, have no effect on the lines, on busy_o or on the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code: 1 start, 2 repeated start, 3 stop, 4 write, 5 read |
| wr_bit_i | input | 1 | Bit value for a write command |
| sda_i | input | 1 | Sensed SDA line level |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when a command ends |
| rd_bit_o | output | 1 | Bit captured by the last read |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the ports is a read whose result depends only on the SDA level in phase C. The stimulus drives the opposite level on sda_i during phases A, B and D, so any capture taken at the wrong time returns the wrong value. A second hard case is a valid strobe that arrives in the middle of a command. The bench strobes a stop partway through a write-0 bit. It then checks that the write's SCL/SDA pattern and its completion time are unchanged, and that no stop follows.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_STOP    = 3'd3,
    CMD_WRITE   = 3'd4,
    CMD_READ    = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_A    = 3'd1,
    PH_B    = 3'd2,
    PH_C    = 3'd3,
    PH_D    = 3'd4
  } phase_e;

  // Quarter-bit length in clocks; times are doubled ns so bit-level minima split over two phases.
  function automatic int quarter_cycles(int clk_hz, bit fast);
    longint t_low, t_high, su_sta, su_sto, need, q;
    t_low  = fast ? 64'd1300 : 64'd4700;
    t_high = fast ? 64'd600  : 64'd4000;
    su_sta = fast ? 64'd600  : 64'd4700;
    su_sto = fast ? 64'd600  : 64'd4000;
    need = t_low;
    if (t_high > need)     need = t_high;
    if (2 * su_sta > need) need = 2 * su_sta;
    if (2 * su_sto > need) need = 2 * su_sto;
    q = (longint'(clk_hz) * need + 64'd1999999999) / 64'd2000000000;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  // Returns {scl_high, sda_high} for one phase of a command.
  function automatic logic [1:0] line_levels(cmd_e c, phase_e p, logic wbit);
    logic [3:0] scl_pat, sda_pat;
    int sel;
    case (c)
      CMD_START:   begin scl_pat = 4'b1110; sda_pat = 4'b1000; end
      CMD_RESTART: begin scl_pat = 4'b0110; sda_pat = 4'b1100; end
      CMD_STOP:    begin scl_pat = 4'b0111; sda_pat = 4'b0011; end
      CMD_WRITE:   begin scl_pat = 4'b0110; sda_pat = {4{wbit}}; end
      default:     begin scl_pat = 4'b0110; sda_pat = 4'b1111; end
    endcase
    case (p)
      PH_A:    sel = 3;
      PH_B:    sel = 2;
      PH_C:    sel = 1;
      default: sel = 0;
    endcase
    return {scl_pat[sel], sda_pat[sel]};
  endfunction

endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
  parameter int QUARTER = 130
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(QUARTER + 1);
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_bit_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic   wr_bit_i,
  input  logic   sda_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output cmd_e   cmd_o,
  output logic   wbit_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   rd_bit_o
);
  phase_e phase_q;
  cmd_e   cmd_q;
  logic   wbit_q, done_q, rd_q;
  logic   code_ok, accept;

  assign code_ok = (cmd_i >= 3'd1) && (cmd_i <= 3'd5);
  assign accept  = (phase_q == PH_IDLE) && cmd_valid_i && code_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cmd_q   <= CMD_NONE;
      wbit_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      done_q <= tick_i && (phase_q == PH_D);
      if (tick_i && (phase_q == PH_C) && (cmd_q == CMD_READ)) rd_q <= sda_i;
      if (accept) begin
        phase_q <= PH_A;
        cmd_q   <= cmd_e'(cmd_i);
        wbit_q  <= wr_bit_i;
      end else if (tick_i) begin
        case (phase_q)
          PH_A:    phase_q <= PH_B;
          PH_B:    phase_q <= PH_C;
          PH_C:    phase_q <= PH_D;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o  = phase_q;
  assign cmd_o    = cmd_q;
  assign wbit_o   = wbit_q;
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;
  assign rd_bit_o = rd_q;
endmodule

// File: rtl/i2c_line_drive.sv
module i2c_line_drive
  import i2c_bit_pkg::*;
(
  input  phase_e phase_i,
  input  cmd_e   cmd_i,
  input  logic   wbit_i,
  output logic   scl_low_o,
  output logic   sda_low_o
);
  logic [1:0] lv;

  always_comb begin
    lv = 2'b11;
    if (phase_i != PH_IDLE) lv = line_levels(cmd_i, phase_i, wbit_i);
  end

  // open drain: a high level is a release, never a drive
  assign scl_low_o = !lv[1];
  assign sda_low_o = !lv[0];
endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
#(
  parameter int CLK_HZ    = 200_000_000,
  parameter bit FAST_MODE = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       wr_bit_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_bit_o,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  localparam int QUARTER = quarter_cycles(CLK_HZ, FAST_MODE);

  phase_e phase;
  cmd_e   cmd_q;
  logic   wbit_q, tick;

  i2c_quarter_timer #(.QUARTER(QUARTER)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  i2c_bit_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .wr_bit_i    (wr_bit_i),
    .sda_i       (sda_i),
    .tick_i      (tick),
    .phase_o     (phase),
    .cmd_o       (cmd_q),
    .wbit_o      (wbit_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rd_bit_o    (rd_bit_o)
  );

  i2c_line_drive u_drive (
    .phase_i   (phase),
    .cmd_i     (cmd_q),
    .wbit_i    (wbit_q),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o)
  );
endmodule

// File: rtl/i2c_bit_ctrl_chk.sv
module i2c_bit_ctrl_chk
  import i2c_bit_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic scl_low_o,
  input logic sda_low_o,
  input cmd_e cmd_q
);
  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  assert_busy_ends_with_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_start_sda_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_START && $rose(scl_low_o)) |-> sda_low_o);

  assert_stop_release_scl_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_STOP && busy_o && $fell(sda_low_o)) |-> !scl_low_o);

  assert_write_sda_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && cmd_q == CMD_WRITE) |-> $stable(sda_low_o));

  assert_idle_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_low_o && !sda_low_o));

  assert_busy_holds_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cmd_q));
endmodule

bind i2c_bit_ctrl i2c_bit_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o),
  .cmd_q     (cmd_q)
);

// File: tb/i2c_bit_ctrl_bench.sv
module i2c_bit_ctrl_bench;
  // 200 MHz, fast mode: quarter = ceil(200e6 * 1.3us / 2) = 130 clocks
  localparam int Q = 130;
  localparam int NV = 8;
  // {cmd[14:12], wbit[11], sda_in_c[10], scl A..D [9:6], sda A..D [5:2], chk_rd[1], exp_rd[0]}; 1 = released
  localparam logic [14:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b1, 4'b1110, 4'b1000, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b1, 4'b0110, 4'b1111, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b1, 4'b0110, 4'b0000, 1'b0, 1'b0},
    {3'd5, 1'b0, 1'b1, 4'b0110, 4'b1111, 1'b1, 1'b1},
    {3'd5, 1'b0, 1'b0, 4'b0110, 4'b1111, 1'b1, 1'b0},
    {3'd2, 1'b0, 1'b1, 4'b0110, 4'b1100, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b1, 4'b0111, 4'b0011, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b1, 4'b0110, 4'b1111, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic wr_bit_i = 1'b0;
  logic sda_i = 1'b1;
  logic busy_o, done_o, rd_bit_o, scl_low_o, sda_low_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic last_rd = 1'b0;

  always #2.5 clk_i = ~clk_i;

  i2c_bit_ctrl u_i2c_bit_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .wr_bit_i(wr_bit_i), .sda_i(sda_i), .busy_o(busy_o), .done_o(done_o),
    .rd_bit_o(rd_bit_o), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic negs(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // strobe for one edge; returns at negedge 0 after the accepting edge
  task automatic issue(logic [2:0] c, logic b);
    cmd_valid_i = 1'b1; cmd_i = c; wr_bit_i = b;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_i = 3'd0;
  endtask

  task automatic run_vec(logic [14:0] v);
    logic [2:0] c;
    string req;
    int ph_exp;
    c = v[14:12];
    case (c)
      3'd1: req = "R3";
      3'd2: req = "R4";
      3'd3: req = "R5";
      3'd4: req = "R6";
      default: req = "R7";
    endcase
    @(negedge clk_i);
    issue(c, v[11]);
    for (int ph = 0; ph < 4; ph++) begin
      sda_i = (ph == 2) ? v[10] : ~v[10];
      negs(Q / 2);
      ph_exp = 3 - ph;
      check(req, $sformatf("scl_low phase %0d", ph), int'(scl_low_o), int'(!v[6 + ph_exp]));
      check(req, $sformatf("sda_low phase %0d", ph), int'(sda_low_o), int'(!v[2 + ph_exp]));
      check("R8", "busy mid phase", int'(busy_o), 1);
      negs(Q - Q / 2);
    end
    // now at negedge 4Q: first idle cycle
    check("R2", "done at 4Q", int'(done_o), 1);
    check("R2", "busy at 4Q", int'(busy_o), 0);
    check("R8", "scl released idle", int'(scl_low_o), 0);
    check("R8", "sda released idle", int'(sda_low_o), 0);
    if (v[1]) last_rd = v[0];
    check("R7", "rd_bit", int'(rd_bit_o), int'(last_rd));
    negs(1);
    check("R2", "done one cycle", int'(done_o), 0);
    sda_i = 1'b1;
  endtask

  initial begin
    #1;
    check("R1", "reset scl", int'(scl_low_o), 0);
    check("R1", "reset sda", int'(sda_low_o), 0);
    check("R1", "reset busy", int'(busy_o), 0);
    check("R1", "reset done", int'(done_o), 0);
    check("R1", "reset rd", int'(rd_bit_o), 0);
    negs(3);
    rst_ni = 1'b1;
    negs(2);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2: phase boundary exactness on a stop (SDA released at start of phase C)
    @(negedge clk_i);
    issue(3'd3, 1'b0);
    negs(2 * Q - 1);
    check("R2", "stop sda still low end of B", int'(sda_low_o), 1);
    negs(1);
    check("R2", "stop sda released start of C", int'(sda_low_o), 0);
    negs(2 * Q - 1);
    check("R2", "no done before 4Q", int'(done_o), 0);
    negs(3);

    // R9: illegal codes
    issue(3'd0, 1'b0);
    check("R9", "code 0 busy", int'(busy_o), 0);
    issue(3'd6, 1'b0);
    check("R9", "code 6 busy", int'(busy_o), 0);
    issue(3'd7, 1'b1);
    check("R9", "code 7 busy", int'(busy_o), 0);
    check("R9", "code 7 lines", int'(scl_low_o | sda_low_o), 0);

    // R9: strobe of a stop while a write-0 runs
    @(negedge clk_i);
    issue(3'd4, 1'b0);
    negs(Q + 3);
    issue(3'd3, 1'b0);
    negs(Q - 4 + Q / 2);
    check("R9", "write sda kept in C", int'(sda_low_o), 1);
    check("R9", "write scl in C", int'(scl_low_o), 0);
    negs(2 * Q - Q / 2);
    check("R9", "done at original 4Q", int'(done_o), 1);
    negs(2);
    check("R9", "no stop started", int'(busy_o), 0);

    // R1: asynchronous reset in the middle of a stop
    @(negedge clk_i);
    issue(3'd3, 1'b0);
    negs(Q / 2);
    check("R1", "stop drives sda before reset", int'(sda_low_o), 1);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1", "async reset sda", int'(sda_low_o), 0);
    check("R1", "async reset scl", int'(scl_low_o), 0);
    check("R1", "async reset busy", int'(busy_o), 0);
    check("R1", "async reset rd", int'(rd_bit_o), 0);
    negs(2);
    rst_ni = 1'b1;
    negs(2);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule